// File: doc/BRIEF.md
# Serial Game-Controller Port Interface

This block sits on a CPU bus and serves two serial game-controller ports. A write to the strobe register loads a three-bit latch. The latch drives three OUT lines that stay at their value until the next write. Bit 0 of the latch goes to the controller port. Bits 2..1 go to the expansion port. A controller uses its OUT line to snapshot its buttons, and then shifts them out one at a time.

Each port has a read register. A read of a port's register pulls that port's clock line low for one cycle. When the clock falls, the port's five data lines are captured, inverted, and returned on read-data bits 4..0. Bits 7..5 of the read data repeat the open-bus value. The bus master supplies that value as an input. Port 1 has no line behind data bit 2. That bit returns a default set by a parameter.

The block does one bus access per clock cycle. It is fully synchronous, with active-high synchronous reset. All outputs are registered.

Top module: `ctrl_port_if`

## Requirements
- R1: After reset, `strobe_out` is 3'b000, both `port_clk` bits are 1 and `bus_rdata` is 8'h00.
- R2: A valid write (`bus_rd`=0) to address 16'h4016 loads `bus_wdata[2:0]` into `strobe_out` on the next cycle. `bus_wdata[7:3]` is ignored. A write to any other address leaves `strobe_out` unchanged, and so does a cycle with no write.
- R3: A valid read (`bus_rd`=1) of 16'h4016 drives `port_clk[0]` low on the next cycle and leaves `port_clk[1]` high. A valid read of 16'h4017 does the reverse. A bit of `port_clk` is low only in a cycle that follows a read of its port.
- R4: A `port_clk` bit returns high in the cycle after an access that is not a read of its port. Back-to-back reads of the same port hold it low without a break.
- R5: On a high-to-low transition of a port's clock, `bus_rdata[4:0]` becomes the inverted level of that port's data lines at the read access. A high line reads as 0 and a low line reads as 1.
- R6: A read of a port whose clock is already low (a back-to-back read) causes no capture. It returns the data captured earlier, even if the lines have changed.
- R7: After a port read, `bus_rdata[7:5]` equals `bus_openbus[7:5]` as it was during the access. `bus_openbus[4:0]` is ignored.
- R8: For port 1, `bus_rdata[2]` always equals the parameter `P1_ABSENT_VAL` (default 0), whatever `port1_line[2]` carries. Port 2 returns all five lines.
- R9: Some accesses leave both `port_clk` bits high and `bus_rdata` unchanged: reads of addresses other than 16'h4016 and 16'h4017, all writes, and cycles with `bus_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus access takes place this cycle |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Write data |
| bus_openbus | input | 8 | Last value seen on the data bus; bits 7..5 are used |
| bus_rdata | output | 8 | Registered read data |
| strobe_out | output | 3 | Latched OUT lines (bit 0 controller port, 2..1 expansion) |
| port_clk | output | 2 | Per-port clock, idle high, low after a read of that port |
| port1_line | input | 5 | Port 1 data line levels D4..D0 |
| port2_line | input | 5 | Port 2 data line levels D4..D0 |

## Verification
One cycle can hold both a release and a capture. When a read of port 1 is followed at once by a read of port 2, port 1's clock rises in the same cycle that port 2's clock falls and port 2's lines are captured. The bench runs this exact pair of reads and checks three things: the two clock bits swap in that cycle and are never both low, and the returned data carry port 2's inverted lines and the open-bus bits of the second access. It also runs a second back-to-back read of the same port after the lines have changed, to show that a clock already low captures nothing new.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int CP_DATA_W  = 8;
  localparam int CP_LINES   = 5;
  localparam int CP_OUT_W   = 3;
  localparam int CP_PORTS   = 2;

  typedef struct packed {
    logic                latch_wr;
    logic [CP_PORTS-1:0] port_rd;
  } cp_access_t;
endpackage

// File: rtl/ctrl_port_decode.sv
module ctrl_port_decode
  import ctrl_port_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT0_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PORT1_ADDR = 16'h4017
) (
  input  logic              valid,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output cp_access_t        acc
);
  localparam logic [ADDR_W-1:0] PORT_ADDRS [CP_PORTS] = '{PORT0_ADDR, PORT1_ADDR};

  assign acc.latch_wr = valid && !rd && (addr == LATCH_ADDR);

  for (genvar p = 0; p < CP_PORTS; p++) begin : g_port_hit
    // Port clock is the NAND of read and address match; here the active term.
    assign acc.port_rd[p] = valid && rd && (addr == PORT_ADDRS[p]);
  end
endmodule

// File: rtl/ctrl_port_latch.sv
module ctrl_port_latch #(
  parameter int OUT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [OUT_W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata[OUT_W-1:0];
  end

  // R2: load and hold
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == $past(wdata[OUT_W-1:0])));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
endmodule

// File: rtl/ctrl_port_sampler.sv
module ctrl_port_sampler #(
  parameter int               LINES       = 5,
  parameter logic [LINES-1:0] PRESENT     = '1,
  parameter logic             ABSENT_VAL  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  logic [LINES-1:0] line,
  output logic             port_clk,
  output logic [LINES-1:0] cap,
  output logic [LINES-1:0] cap_next
);
  logic falling;
  logic [LINES-1:0] sampled;

  // A falling clock edge happens only when the line is currently high.
  assign falling = rd_hit && port_clk;

  for (genvar b = 0; b < LINES; b++) begin : g_bit
    if (PRESENT[b]) begin : g_wired
      assign sampled[b] = ~line[b];
    end else begin : g_absent
      assign sampled[b] = ABSENT_VAL;
    end
  end

  assign cap_next = falling ? sampled : cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_clk <= 1'b1;
      cap      <= '0;
    end else begin
      port_clk <= ~rd_hit;
      cap      <= cap_next;
    end
  end

  // R3: clock low only after a read of this port
  a_r3_low_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> !port_clk);
  // R4: clock high after any other cycle
  a_r4_idle_high: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> port_clk);
  // R5: fresh capture is the inverted line level on wired bits
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && port_clk) |=> ((cap & PRESENT) == (~$past(line) & PRESENT)));
  // R6: no new edge, no new capture
  a_r6_no_recapture: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !port_clk) |=> $stable(cap));
endmodule

// File: rtl/ctrl_port_if.sv
module ctrl_port_if
  import ctrl_port_pkg::*;
#(
  parameter int   ADDR_W        = 16,
  parameter logic P1_ABSENT_VAL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CP_DATA_W-1:0] bus_wdata,
  input  logic [CP_DATA_W-1:0] bus_openbus,
  output logic [CP_DATA_W-1:0] bus_rdata,
  output logic [CP_OUT_W-1:0]  strobe_out,
  output logic [CP_PORTS-1:0]  port_clk,
  input  logic [CP_LINES-1:0]  port1_line,
  input  logic [CP_LINES-1:0]  port2_line
);
  localparam int HI_W = CP_DATA_W - CP_LINES;
  localparam logic [CP_LINES-1:0] P1_PRESENT = 5'b11011;
  localparam logic [CP_LINES-1:0] P2_PRESENT = 5'b11111;

  cp_access_t acc;
  logic [CP_LINES-1:0] lines    [CP_PORTS];
  logic [CP_LINES-1:0] cap      [CP_PORTS];
  logic [CP_LINES-1:0] cap_next [CP_PORTS];

  assign lines[0] = port1_line;
  assign lines[1] = port2_line;

  ctrl_port_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid (bus_valid),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .acc   (acc)
  );

  ctrl_port_latch #(.OUT_W(CP_OUT_W), .DATA_W(CP_DATA_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .wr    (acc.latch_wr),
    .wdata (bus_wdata),
    .q     (strobe_out)
  );

  for (genvar p = 0; p < CP_PORTS; p++) begin : g_port
    ctrl_port_sampler #(
      .LINES      (CP_LINES),
      .PRESENT    ((p == 0) ? P1_PRESENT : P2_PRESENT),
      .ABSENT_VAL (P1_ABSENT_VAL)
    ) u_sampler (
      .clk      (clk),
      .rst      (rst),
      .rd_hit   (acc.port_rd[p]),
      .line     (lines[p]),
      .port_clk (port_clk[p]),
      .cap      (cap[p]),
      .cap_next (cap_next[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (acc.port_rd[0]) begin
      bus_rdata <= {bus_openbus[CP_DATA_W-1 -: HI_W], cap_next[0]};
    end else if (acc.port_rd[1]) begin
      bus_rdata <= {bus_openbus[CP_DATA_W-1 -: HI_W], cap_next[1]};
    end
  end

  // R3: at most one port clock low at a time
  a_r3_one_low: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~port_clk));
  // R7: open-bus bits pass through on port reads
  a_r7_openbus: assert property (@(posedge clk) disable iff (rst)
    (|acc.port_rd) |=> (bus_rdata[CP_DATA_W-1 -: HI_W] == $past(bus_openbus[CP_DATA_W-1 -: HI_W])));
  // R8: absent port-1 line returns the default
  a_r8_absent: assert property (@(posedge clk) disable iff (rst)
    acc.port_rd[0] |=> (bus_rdata[2] == P1_ABSENT_VAL));
  // R9: non-port accesses leave read data and clocks alone
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|acc.port_rd) |=> ($stable(bus_rdata) && (&port_clk)));
endmodule

// File: tb/ctrl_port_if_tb_top.sv
`timescale 1ns/1ps
module ctrl_port_if_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0;
  logic       bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_openbus = '0;
  logic [7:0] bus_rdata;
  logic [2:0] strobe_out;
  logic [1:0] port_clk;
  logic [4:0] port1_line = '0;
  logic [4:0] port2_line = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ctrl_port_if dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_openbus(bus_openbus),
    .bus_rdata(bus_rdata), .strobe_out(strobe_out), .port_clk(port_clk),
    .port1_line(port1_line), .port2_line(port2_line)
  );

  // {rd, asel, wdata, openbus[7:5], p1, p2, exp_rdata, exp_clk, exp_out}
  localparam int VW = 37;
  localparam int NV = 9;
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0, 2'd0, 8'hFD, 3'b000, 5'b00000, 5'b00000, 8'h00, 2'b11, 3'b101},
    {1'b1, 2'd0, 8'h00, 3'b101, 5'b10100, 5'b00000, 8'hAB, 2'b10, 3'b101},
    {1'b1, 2'd1, 8'h00, 3'b010, 5'b11111, 5'b00000, 8'h5F, 2'b01, 3'b101},
    {1'b1, 2'd0, 8'h00, 3'b000, 5'b00000, 5'b00000, 8'h1B, 2'b10, 3'b101},
    {1'b0, 2'd0, 8'h02, 3'b000, 5'b00000, 5'b00000, 8'h1B, 2'b11, 3'b010},
    {1'b1, 2'd2, 8'h00, 3'b111, 5'b00000, 5'b00000, 8'h1B, 2'b11, 3'b010},
    {1'b1, 2'd1, 8'h00, 3'b111, 5'b00000, 5'b01010, 8'hF5, 2'b01, 3'b010},
    {1'b0, 2'd1, 8'h07, 3'b000, 5'b00000, 5'b00000, 8'hF5, 2'b11, 3'b010},
    {1'b1, 2'd0, 8'h00, 3'b011, 5'b11111, 5'b00000, 8'h60, 2'b10, 3'b010}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] sel_addr(input logic [1:0] s);
    case (s)
      2'd0:    return 16'h4016;
      2'd1:    return 16'h4017;
      default: return 16'h4015;
    endcase
  endfunction

  // Drive one access at a falling edge; return at the next falling edge.
  task automatic access(input logic v, input logic rd, input logic [15:0] a,
                        input logic [7:0] wd, input logic [2:0] ob);
    bus_valid   = v;
    bus_rd      = rd;
    bus_addr    = a;
    bus_wdata   = wd;
    bus_openbus = {ob, 5'b10101};
    @(negedge clk);
  endtask

  task automatic idle();
    access(1'b0, 1'b0, 16'h0000, 8'h00, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 out", {5'b0, strobe_out}, 8'h00);
    chk("R1 clk", {6'b0, port_clk}, 8'h03);
    chk("R1 rdata", bus_rdata, 8'h00);

    // Table walk: each vector is one access followed by one idle cycle.
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      port1_line = v[22:18];
      port2_line = v[17:13];
      access(1'b1, v[36], sel_addr(v[35:34]), v[33:26], v[25:23]);
      chk($sformatf("R5/R7/R8 vec%0d rdata", i), bus_rdata, v[12:5]);
      chk($sformatf("R3/R9 vec%0d clk", i), {6'b0, port_clk}, {6'b0, v[4:3]});
      chk($sformatf("R2 vec%0d out", i), {5'b0, strobe_out}, {5'b0, v[2:0]});
      idle();
      chk($sformatf("R4 vec%0d idle clk", i), {6'b0, port_clk}, 8'h03);
    end

    // R8: port-1 bit 2 low on the line still reads default 0
    port1_line = 5'b11011;
    access(1'b1, 1'b1, 16'h4016, 8'h00, 3'b000);
    chk("R8 absent line", bus_rdata, 8'h00);
    idle();

    // R6 / R4: back-to-back reads of port 1, lines change in between
    port1_line = 5'b00000;
    access(1'b1, 1'b1, 16'h4016, 8'h00, 3'b001);
    chk("R5 first read", bus_rdata, 8'h3B);
    port1_line = 5'b11111;
    access(1'b1, 1'b1, 16'h4016, 8'h00, 3'b110);
    chk("R6 no recapture", bus_rdata, 8'hDB);
    chk("R4 held low", {6'b0, port_clk}, 8'h02);

    // Port 1 release and port 2 capture in the same cycle
    port2_line = 5'b11100;
    access(1'b1, 1'b1, 16'h4017, 8'h00, 3'b100);
    chk("R3 swap clk", {6'b0, port_clk}, 8'h01);
    chk("R5 p2 after p1", bus_rdata, 8'h83);
    idle();
    chk("R9 idle rdata", bus_rdata, 8'h83);

    // R9: invalid cycle with read of port 1 address
    access(1'b0, 1'b1, 16'h4016, 8'h00, 3'b111);
    chk("R9 invalid clk", {6'b0, port_clk}, 8'h03);
    chk("R9 invalid rdata", bus_rdata, 8'h83);

    // R2: upper write bits ignored, value held
    access(1'b1, 1'b0, 16'h4016, 8'hF8, 3'b000);
    chk("R2 upper ignored", {5'b0, strobe_out}, 8'h00);
    chk("R9 write clk", {6'b0, port_clk}, 8'h03);
    access(1'b1, 1'b0, 16'h4016, 8'h07, 3'b000);
    idle();
    idle();
    chk("R2 held", {5'b0, strobe_out}, 8'h07);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset out", {5'b0, strobe_out}, 8'h00);
    chk("R1 reset rdata", bus_rdata, 8'h00);
    chk("R1 reset clk", {6'b0, port_clk}, 8'h03);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule